// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps recently used linear-to-physical page translations close to the pipeline so that a translation hit avoids a two-level table walk. A requester presents a 20-bit linear page number (linear address bits 31:12) together with write and user-privilege flags. One cycle later the block answers with exactly one of three outcomes: a hit carrying the 20-bit physical page base, a miss that sends the requester to the table walker, or a protection fault.

Storage is 32 entries, organised as eight sets of four ways, and each entry maps one 4 KB page, so the buffer covers 128 KB. The walker installs translations through a fill port that carries the cached permission bits. Two maintenance operations remove entries. The first is a whole-buffer flush, raised when the root page-table register is reloaded. The second is a single-page invalidate that drops only the entry matching a given linear page.

Top module: `tlb_top`

## Requirements
- R1: Every cycle with `req_valid` high gives exactly one response on the following cycle, with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` set. No response appears without a request.
- R2: The set index is page-number bits 2:0 (linear address bits 14:12), and the tag is page-number bits 19:3. Eight sets of four ways hold 32 distinct translations at the same time, and each one hits with its own `rsp_ppn`.
- R3: After reset, `rsp_valid` is low and every lookup misses.
- R4: A cycle with `flush_all` high invalidates every entry, and later lookups miss.
- R5: `inval_valid` removes only the entry whose page number equals `inval_vpn`. Other entries in the same set keep hitting, and an invalidate that matches nothing changes nothing.
- R6: A user access (`req_user`=1) that hits an entry whose cached user bit is 0 reports `rsp_fault` with `rsp_ppn`=0. Supervisor accesses to that entry hit.
- R7: A write that hits an entry whose writable bit is 0 reports `rsp_fault`, and this check takes precedence over the dirty check (R8). Reads of that entry hit.
- R8: A permitted write that hits an entry whose cached dirty bit is 0 reports a miss. A read of that entry, or a write after the entry is refilled with dirty=1, hits.
- R9: A fill places the entry in the lowest-numbered invalid way of its set. If the set is full, the victim comes from a per-set binary-tree pseudo-LRU, which every successful hit and every fill updates.
- R10: When `flush_all` or `inval_valid` is high, a fill in the same cycle is discarded.
- R11: A fill whose page number is already cached overwrites that entry in place, so no page is held twice.
- R12: A lookup returns the result from the contents as they stood in its request cycle. A same-cycle flush, fill or invalidate affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | 20 | Linear page number to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made at user privilege |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | Walker must be used |
| rsp_fault | output | 1 | Protection violation on a cached entry |
| rsp_ppn | output | 20 | Physical page base on a hit, else 0 |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Linear page number of the fill |
| fill_ppn | input | 20 | Physical page base of the fill |
| fill_user | input | 1 | Entry allows user access |
| fill_writable | input | 1 | Entry allows writes |
| fill_dirty | input | 1 | Page already marked dirty |
| flush_all | input | 1 | Root register load: drop every entry |
| inval_valid | input | 1 | Drop the single entry for `inval_vpn` |
| inval_vpn | input | 20 | Linear page number to invalidate |

## Verification
The embedded properties check on every cycle that each request gets exactly one response one cycle later, with one outcome flag and a zero page base on a fault. They also check that a flush leaves no valid entry and that a tag never matches two ways of a set. Replacement order, the way a later fill lands in a freed way, the split between fault and dirty-miss, and the priority of flush and invalidate over a same-cycle fill depend on earlier history. Only the bench's directed sequences show these: it fills a set, reads it back in a known order and predicts which page a new fill evicts.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        RK_MISS  = 2'd0,
        RK_HIT   = 2'd1,
        RK_FAULT = 2'd2
    } rsp_kind_e;

    typedef struct packed {
        logic user;
        logic writable;
        logic dirty;
    } perm_t;

endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 17,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       any_hit,
    output logic [WAY_W-1:0]           hit_way
);

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = way_valid[w] && (way_tag[w] == probe_tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        any_hit = |hit_vec;
    end

endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
    parameter int WAYS = 4,
    parameter int SETS = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             a_en,
    input  logic [SET_W-1:0] a_set,
    input  logic [WAY_W-1:0] a_way,
    input  logic             b_en,
    input  logic [SET_W-1:0] b_set,
    input  logic [WAY_W-1:0] b_way,
    input  logic [SET_W-1:0] q_set,
    output logic [WAY_W-1:0] victim
);

    typedef logic [WAYS-2:0] tree_t;

    typedef struct packed {
        logic [SETS-1:0][WAYS-2:0] tree;
    } plru_state_t;

    plru_state_t st_d, st_q;

    // Walk from the root: each node bit names the half holding the victim.
    function automatic logic [WAY_W-1:0] pick(input tree_t t);
        logic [WAY_W-1:0] v;
        int node;
        v    = '0;
        node = 1;
        for (int l = 0; l < WAY_W; l++) begin
            v    = {v[WAY_W-2:0], t[node-1]};
            node = 2 * node + (t[node-1] ? 1 : 0);
        end
        return v;
    endfunction

    // Point every node on the path away from the way just used.
    function automatic tree_t touch(input tree_t t, input logic [WAY_W-1:0] way);
        tree_t r;
        int node;
        logic dir;
        r    = t;
        node = 1;
        for (int l = 0; l < WAY_W; l++) begin
            dir       = way[WAY_W-1-l];
            r[node-1] = ~dir;
            node      = 2 * node + (dir ? 1 : 0);
        end
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.tree = '0;
        end else begin
            if (a_en) st_d.tree[a_set] = touch(st_d.tree[a_set], a_way);
            if (b_en) st_d.tree[b_set] = touch(st_d.tree[b_set], b_way);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign victim = pick(st_q.tree[q_set]);

endmodule

// File: rtl/tlb_top.sv
module tlb_top #(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_write,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PPN_W-1:0] rsp_ppn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_user,
    input  logic             fill_writable,
    input  logic             fill_dirty,
    input  logic             flush_all,
    input  logic             inval_valid,
    input  logic [VPN_W-1:0] inval_vpn
);
    import tlb_pkg::*;

    localparam int WAY_W = $clog2(WAYS);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - SET_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn;
        perm_t [SETS-1:0][WAYS-1:0]            perm;
        logic                                  rsp_valid;
        rsp_kind_e                             rsp_kind;
        logic [PPN_W-1:0]                      rsp_ppn;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [SET_W-1:0] lk_set, fl_set, iv_set;
    logic [TAG_W-1:0] lk_tag, fl_tag, iv_tag;
    logic [WAYS-1:0]  lk_hit_vec, fl_hit_vec, iv_hit_vec;
    logic             lk_any, fl_any, iv_any;
    logic [WAY_W-1:0] lk_way, fl_way, iv_way, plru_victim;
    logic [WAY_W-1:0] free_way, fl_target;
    logic             has_free, fill_go, touch_lk;
    rsp_kind_e        lk_kind;
    perm_t            lk_perm;

    assign lk_set = req_vpn[SET_W-1:0];
    assign lk_tag = req_vpn[VPN_W-1:SET_W];
    assign fl_set = fill_vpn[SET_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:SET_W];
    assign iv_set = inval_vpn[SET_W-1:0];
    assign iv_tag = inval_vpn[VPN_W-1:SET_W];

    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_lk (
        .way_tag(st_q.tag[lk_set]), .way_valid(st_q.valid[lk_set]), .probe_tag(lk_tag),
        .hit_vec(lk_hit_vec), .any_hit(lk_any), .hit_way(lk_way));

    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_fl (
        .way_tag(st_q.tag[fl_set]), .way_valid(st_q.valid[fl_set]), .probe_tag(fl_tag),
        .hit_vec(fl_hit_vec), .any_hit(fl_any), .hit_way(fl_way));

    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_iv (
        .way_tag(st_q.tag[iv_set]), .way_valid(st_q.valid[iv_set]), .probe_tag(iv_tag),
        .hit_vec(iv_hit_vec), .any_hit(iv_any), .hit_way(iv_way));

    tlb_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
        .clk(clk), .rst_n(rst_n), .clear(flush_all),
        .a_en(touch_lk), .a_set(lk_set), .a_way(lk_way),
        .b_en(fill_go), .b_set(fl_set), .b_way(fl_target),
        .q_set(fl_set), .victim(plru_victim));

    // Lookup classification: fault outranks the dirty-bit miss.
    always_comb begin
        lk_perm = st_q.perm[lk_set][lk_way];
        if (!lk_any)
            lk_kind = RK_MISS;
        else if ((req_user && !lk_perm.user) || (req_write && !lk_perm.writable))
            lk_kind = RK_FAULT;
        else if (req_write && !lk_perm.dirty)
            lk_kind = RK_MISS;
        else
            lk_kind = RK_HIT;
        touch_lk = req_valid && (lk_kind == RK_HIT);
    end

    // Fill placement: existing entry, else lowest free way, else tree victim.
    always_comb begin
        has_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!st_q.valid[fl_set][w]) begin
                has_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        fl_target = fl_any ? fl_way : (has_free ? free_way : plru_victim);
        fill_go   = fill_valid && !flush_all && !inval_valid;
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_kind  = req_valid ? lk_kind : RK_MISS;
        st_d.rsp_ppn   = (req_valid && lk_kind == RK_HIT) ? st_q.ppn[lk_set][lk_way] : '0;

        if (fill_go) begin
            st_d.valid[fl_set][fl_target] = 1'b1;
            st_d.tag[fl_set][fl_target]   = fl_tag;
            st_d.ppn[fl_set][fl_target]   = fill_ppn;
            st_d.perm[fl_set][fl_target]  = '{user: fill_user, writable: fill_writable,
                                               dirty: fill_dirty};
        end
        if (inval_valid && iv_any)
            st_d.valid[iv_set][iv_way] = 1'b0;
        if (flush_all)
            st_d.valid = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_valid && (st_q.rsp_kind == RK_HIT);
    assign rsp_miss  = st_q.rsp_valid && (st_q.rsp_kind == RK_MISS);
    assign rsp_fault = st_q.rsp_valid && (st_q.rsp_kind == RK_FAULT);
    assign rsp_ppn   = st_q.rsp_ppn;

    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
    a_r6_fault_no_ppn: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_ppn == '0);
    a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> st_q.valid == '0);
    a_r11_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(lk_hit_vec));

endmodule

// File: tb/tlb_top_test.sv
module tlb_top_test;
    import tlb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_user;
    logic [19:0] req_vpn;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [19:0] rsp_ppn;
    logic        fill_valid, fill_user, fill_writable, fill_dirty;
    logic [19:0] fill_vpn, fill_ppn;
    logic        flush_all, inval_valid;
    logic [19:0] inval_vpn;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        rsp_kind_e   kind;
        logic [19:0] ppn;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    rsp_kind_e got;

    always #10 clk = ~clk;

    tlb_top uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_ppn(rsp_ppn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_user(fill_user), .fill_writable(fill_writable), .fill_dirty(fill_dirty),
        .flush_all(flush_all), .inval_valid(inval_valid), .inval_vpn(inval_vpn));

    function automatic logic [19:0] mk(input int tag, input int set);
        return {tag[16:0], set[2:0]};
    endfunction

    task automatic idle();
        req_valid = 0; req_vpn = '0; req_write = 0; req_user = 0;
        fill_valid = 0; fill_vpn = '0; fill_ppn = '0;
        fill_user = 0; fill_writable = 0; fill_dirty = 0;
        flush_all = 0; inval_valid = 0; inval_vpn = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        idle();
    endtask

    task automatic stage_look(input logic [19:0] vpn, input logic wr, input logic usr,
                              input rsp_kind_e kind, input logic [19:0] ppn, input string r);
        req_valid = 1; req_vpn = vpn; req_write = wr; req_user = usr;
        exp_q.push_back('{kind: kind, ppn: ppn, req: r});
    endtask

    task automatic stage_fill(input logic [19:0] vpn, input logic [19:0] ppn,
                              input logic u, input logic w, input logic d);
        fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn;
        fill_user = u; fill_writable = w; fill_dirty = d;
    endtask

    task automatic look(input logic [19:0] vpn, input logic wr, input logic usr,
                        input rsp_kind_e kind, input logic [19:0] ppn, input string r);
        stage_look(vpn, wr, usr, kind, ppn, r);
        tick();
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic u, input logic w, input logic d);
        stage_fill(vpn, ppn, u, w, d);
        tick();
    endtask

    task automatic flush();
        flush_all = 1;
        tick();
    endtask

    task automatic inval(input logic [19:0] vpn);
        inval_valid = 1; inval_vpn = vpn;
        tick();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Monitor: pop one expectation per response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            got = rsp_fault ? RK_FAULT : (rsp_hit ? RK_HIT : RK_MISS);
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected response: got %s ppn %h, expected none",
                         got.name(), rsp_ppn);
            end else begin
                cur = exp_q.pop_front();
                if (got != cur.kind || rsp_ppn != cur.ppn) begin
                    fails++;
                    $display("FAIL %s: got %s ppn %h, expected %s ppn %h",
                             cur.req, got.name(), rsp_ppn, cur.kind.name(), cur.ppn);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R3 reset rsp_valid: got %b, expected 0", rsp_valid);
        end
        @(posedge clk);
        #2 rst_n = 1;

        // R3: empty after reset
        look(mk(2, 1), 0, 0, RK_MISS, 20'h0, "R3 lookup after reset");

        // R2: basic hit
        fill(mk(2, 1), 20'hABCDE, 1, 1, 1);
        look(mk(2, 1), 0, 1, RK_HIT, 20'hABCDE, "R2 user read hit");
        look(mk(2, 1), 1, 1, RK_HIT, 20'hABCDE, "R2 user write hit");
        look(mk(3, 1), 0, 0, RK_MISS, 20'h0, "R2 tag mismatch miss");

        // R4: flush drops the entry
        flush();
        look(mk(2, 1), 0, 0, RK_MISS, 20'h0, "R4 after flush");

        // R2: full capacity, 32 distinct translations
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++)
                fill(mk(100 + w, s), 20'(32'h100 + s * 4 + w), 1, 1, 1);
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++)
                look(mk(100 + w, s), 0, 0, RK_HIT, 20'(32'h100 + s * 4 + w), "R2 capacity hit");
        flush();
        for (int s = 0; s < 8; s++)
            look(mk(100 + s % 4, s), 0, 0, RK_MISS, 20'h0, "R4 capacity flushed");

        // R6 / R7 / R8 / R11: permissions, dirty, overwrite
        fill(mk(40, 6), 20'h60001, 0, 1, 1);
        fill(mk(41, 6), 20'h60002, 1, 0, 0);
        fill(mk(42, 6), 20'h60003, 1, 1, 0);
        look(mk(40, 6), 0, 1, RK_FAULT, 20'h0, "R6 user to supervisor page");
        look(mk(40, 6), 1, 0, RK_HIT, 20'h60001, "R6 supervisor write hit");
        look(mk(41, 6), 1, 1, RK_FAULT, 20'h0, "R7 write to read-only");
        look(mk(41, 6), 0, 1, RK_HIT, 20'h60002, "R7 read of read-only");
        look(mk(42, 6), 1, 1, RK_MISS, 20'h0, "R8 write with dirty clear");
        look(mk(42, 6), 0, 1, RK_HIT, 20'h60003, "R8 read with dirty clear");
        fill(mk(42, 6), 20'h60004, 1, 1, 1);
        look(mk(42, 6), 1, 1, RK_HIT, 20'h60004, "R11 refill overwrites, R8 dirty set");
        fill(mk(43, 6), 20'h60005, 1, 1, 1);
        look(mk(40, 6), 0, 0, RK_HIT, 20'h60001, "R11 no duplicate way 0");
        look(mk(41, 6), 0, 0, RK_HIT, 20'h60002, "R11 no duplicate way 1");
        look(mk(42, 6), 0, 0, RK_HIT, 20'h60004, "R11 no duplicate way 2");
        look(mk(43, 6), 0, 0, RK_HIT, 20'h60005, "R11 no duplicate way 3");

        // R5: single-entry invalidate
        fill(mk(50, 3), 20'h30050, 1, 1, 1);
        fill(mk(51, 3), 20'h30051, 1, 1, 1);
        inval(mk(50, 3));
        look(mk(50, 3), 0, 0, RK_MISS, 20'h0, "R5 invalidated entry");
        look(mk(51, 3), 0, 0, RK_HIT, 20'h30051, "R5 neighbour kept");
        inval(mk(52, 3));
        look(mk(51, 3), 0, 0, RK_HIT, 20'h30051, "R5 unmatched invalidate");

        // R9: pseudo-LRU victim and invalid-first
        flush();
        for (int t = 0; t < 4; t++)
            fill(mk(10 + t, 5), 20'(32'h50000 + t), 1, 1, 1);
        look(mk(10, 5), 0, 0, RK_HIT, 20'h50000, "R9 touch A");
        fill(mk(14, 5), 20'h50004, 1, 1, 1);
        look(mk(10, 5), 0, 0, RK_HIT, 20'h50000, "R9 A kept");
        look(mk(11, 5), 0, 0, RK_HIT, 20'h50001, "R9 B kept");
        look(mk(12, 5), 0, 0, RK_MISS, 20'h0, "R9 C evicted");
        look(mk(13, 5), 0, 0, RK_HIT, 20'h50003, "R9 D kept");
        look(mk(14, 5), 0, 0, RK_HIT, 20'h50004, "R9 E installed");
        inval(mk(11, 5));
        fill(mk(15, 5), 20'h50005, 1, 1, 1);
        look(mk(10, 5), 0, 0, RK_HIT, 20'h50000, "R9 free way used before victim");
        look(mk(13, 5), 0, 0, RK_HIT, 20'h50003, "R9 D after free fill");
        look(mk(14, 5), 0, 0, RK_HIT, 20'h50004, "R9 E after free fill");
        look(mk(15, 5), 0, 0, RK_HIT, 20'h50005, "R9 F installed");

        // R10: flush and invalidate beat a same-cycle fill
        stage_fill(mk(20, 2), 20'h22220, 1, 1, 1);
        flush_all = 1;
        tick();
        look(mk(20, 2), 0, 0, RK_MISS, 20'h0, "R10 fill lost to flush");
        fill(mk(21, 2), 20'h22221, 1, 1, 1);
        stage_fill(mk(22, 2), 20'h22222, 1, 1, 1);
        inval_valid = 1; inval_vpn = mk(21, 2);
        tick();
        look(mk(21, 2), 0, 0, RK_MISS, 20'h0, "R10 invalidate applied");
        look(mk(22, 2), 0, 0, RK_MISS, 20'h0, "R10 fill lost to invalidate");

        // R12: lookup sees state of its own cycle
        fill(mk(30, 4), 20'h44444, 1, 1, 1);
        stage_look(mk(30, 4), 0, 0, RK_HIT, 20'h44444, "R12 lookup with same-cycle flush");
        flush_all = 1;
        tick();
        look(mk(30, 4), 0, 0, RK_MISS, 20'h0, "R12 after flush");
        stage_look(mk(31, 4), 0, 0, RK_MISS, 20'h0, "R12 lookup with same-cycle fill");
        stage_fill(mk(31, 4), 20'h44445, 1, 1, 1);
        tick();
        look(mk(31, 4), 0, 0, RK_HIT, 20'h44445, "R12 fill visible next cycle");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1 missing responses: got %0d pending, expected 0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule